// File: doc/BRIEF.md
# March Self-Test Controller for a Two-Read, One-Write Register Array

This block sits between the functional logic and a small register array that has two read ports and one write port. When idle it is transparent: every array-side enable, address and write-data output follows the matching functional input. A single-cycle start pulse hands the array ports to an internal sequencer. The sequencer then runs a march test in two halves.

The ascending half fills the array with zeros. It then walks up the addresses three times: read zeros and write ones, read ones and write zeros, then read zeros only. The descending half fills the array with ones from the top address down. It then walks down twice: read ones and write zeros, then read zeros only. A last ascending pass reads zeros through the second read port.

The array is assumed to return read data one cycle after a read enable. Every read element therefore spends one cycle issuing the read and a second cycle comparing the data and issuing any write. Correct reads are counted separately for each half. At the end of the run the block raises either a pass flag or one or both direction fail flags. These flags are held until the next start or reset.

Top module: `march_bist_ctrl`

## Requirements
- R1: After reset the status output equals 0x3F (idle code, all flags clear), and test_pass, test_fail, fail_up and fail_down are 0.
- R2: While idle, each array-side read enable, read address, write enable, write address and write data output equals its functional counterpart.
- R3: While a run is active the array-side ports are driven only by the sequencer. In the first active cycle the write port writes all zeros to address 0 and read port 0 is disabled, whatever the functional inputs carry.
- R4: run_start high for one cycle while idle starts a run, and start pulses during a run are ignored. A run on a 64-word array lasts exactly 896 cycles before the phase code returns to 0x3F.
- R5: The phase code steps through 0,1,2,3,4,5,6,7 in that order and then returns to idle. Fill phases 0 and 4 last one cycle per address (64 cycles), and every read phase lasts two cycles per address (128 cycles).
- R6: In every read-then-write element, the write goes to the address that read port 0 read in the previous cycle. Descending phases (4, 5, 6) visit addresses from the top down, and all other phases visit them from the bottom up.
- R7: A run with no data mismatch ends with test_pass=1 and all fail flags 0. test_pass and test_fail are never high together.
- R8: A mismatch seen by read port 0 in phases 1 to 3 sets fail_up and test_fail at the end of the run, and test_pass stays 0.
- R9: A mismatch in phases 5 or 6, or any mismatch on read port 1 in phase 7, sets fail_down and test_fail at the end of the run.
- R10: The result flags hold their value while idle and are cleared at the start of the next run.
- R11: The status word carries the phase code in bits [5:0], pass in bit 8, fail_up in bit 9 and fail_down in bit 10, with all other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_start | input | 1 | One-cycle start request from a control register |
| status | output | STAT_W | Phase code and result flags |
| fn_rd0_en | input | 1 | Functional read port 0 enable |
| fn_rd0_addr | input | ADDR_W | Functional read port 0 address |
| fn_rd1_en | input | 1 | Functional read port 1 enable |
| fn_rd1_addr | input | ADDR_W | Functional read port 1 address |
| fn_wr_en | input | 1 | Functional write enable |
| fn_wr_addr | input | ADDR_W | Functional write address |
| fn_wr_data | input | DATA_W | Functional write data |
| arr_rd0_en | output | 1 | Array read port 0 enable |
| arr_rd0_addr | output | ADDR_W | Array read port 0 address |
| arr_rd0_data | input | DATA_W | Array read port 0 data, one cycle after enable |
| arr_rd1_en | output | 1 | Array read port 1 enable |
| arr_rd1_addr | output | ADDR_W | Array read port 1 address |
| arr_rd1_data | input | DATA_W | Array read port 1 data, one cycle after enable |
| arr_wr_en | output | 1 | Array write enable |
| arr_wr_addr | output | ADDR_W | Array write address |
| arr_wr_data | output | DATA_W | Array write data |
| test_pass | output | 1 | Both halves clean |
| test_fail | output | 1 | Either half failed |
| fail_up | output | 1 | Ascending half failed |
| fail_down | output | 1 | Descending half failed |

## Verification
The assertions take for granted that run_start is a single-cycle pulse driven from an external control bit. They also assume the array returns read data exactly one cycle after a read enable. Otherwise the comparison cycle would see stale data and the direction flags would have no meaning. The bench pulses run_start for one cycle from the falling edge and models the array with registered read outputs. It injects a stuck bit only through the read path, either for the whole run or gated by the phase code seen at the status output. The functional inputs carry conflicting values throughout to show that they are ignored during a run.

// File: rtl/march_bist_pkg.sv
package march_bist_pkg;

    localparam int unsigned PHASE_W = 6;

    typedef enum logic [PHASE_W-1:0] {
        PH_UP_W0   = 6'd0,
        PH_UP_R0W1 = 6'd1,
        PH_UP_R1W0 = 6'd2,
        PH_UP_R0   = 6'd3,
        PH_DN_W1   = 6'd4,
        PH_DN_R1W0 = 6'd5,
        PH_DN_R0   = 6'd6,
        PH_P1_R0   = 6'd7,
        PH_IDLE    = 6'h3F
    } phase_e;

    // Per-phase control word
    typedef struct packed {
        logic rd0;
        logic rd1;
        logic wr;
        logic exp_ones;
        logic wr_ones;
        logic descending;
        logic down_run;
        logic two_step;
    } phase_ctl_t;

    // Read passes per half (ascending: 3 on port 0; descending: 2 on port 0 + 1 on port 1)
    localparam int unsigned READ_PASSES = 3;

    function automatic phase_ctl_t phase_decode(input phase_e ph);
        phase_ctl_t c;
        c = '0;
        case (ph)
            PH_UP_W0: begin
                c.wr = 1'b1;
            end
            PH_UP_R0W1: begin
                c.rd0 = 1'b1; c.wr = 1'b1; c.wr_ones = 1'b1; c.two_step = 1'b1;
            end
            PH_UP_R1W0: begin
                c.rd0 = 1'b1; c.wr = 1'b1; c.exp_ones = 1'b1; c.two_step = 1'b1;
            end
            PH_UP_R0: begin
                c.rd0 = 1'b1; c.two_step = 1'b1;
            end
            PH_DN_W1: begin
                c.wr = 1'b1; c.wr_ones = 1'b1; c.descending = 1'b1; c.down_run = 1'b1;
            end
            PH_DN_R1W0: begin
                c.rd0 = 1'b1; c.wr = 1'b1; c.exp_ones = 1'b1; c.descending = 1'b1;
                c.down_run = 1'b1; c.two_step = 1'b1;
            end
            PH_DN_R0: begin
                c.rd0 = 1'b1; c.descending = 1'b1; c.down_run = 1'b1; c.two_step = 1'b1;
            end
            PH_P1_R0: begin
                c.rd1 = 1'b1; c.down_run = 1'b1; c.two_step = 1'b1;
            end
            default: c = '0;
        endcase
        return c;
    endfunction

    function automatic phase_e phase_next(input phase_e ph);
        phase_e n;
        if (ph == PH_P1_R0 || ph == PH_IDLE)
            n = PH_IDLE;
        else
            n = phase_e'(ph + 6'd1);
        return n;
    endfunction

endpackage

// File: rtl/bist_addr_ctr.sv
module bist_addr_ctr #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              load_top,
    input  logic              step,
    input  logic              down,
    output logic [ADDR_W-1:0] addr,
    output logic              at_end
);
    localparam logic [ADDR_W-1:0] TOP = '1;
    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst)
            addr <= '0;
        else if (load)
            addr <= load_top ? TOP : '0;
        else if (step)
            addr <= down ? (addr - ONE) : (addr + ONE);
    end

    assign at_end = down ? (addr == '0) : (addr == TOP);

endmodule

// File: rtl/bist_seq.sv
module bist_seq
    import march_bist_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   at_end,
    output phase_e phase,
    output logic   sub,
    output logic   active,
    output logic   start_go,
    output logic   run_end,
    output logic   ctr_load,
    output logic   ctr_load_top,
    output logic   ctr_step
);
    phase_e     phase_q;
    logic       sub_q;
    phase_ctl_t pc;
    phase_ctl_t nc;
    logic       elem_done;
    logic       last_elem;

    assign pc        = phase_decode(phase_q);
    assign nc        = phase_decode(phase_next(phase_q));
    assign active    = (phase_q != PH_IDLE);
    assign start_go  = !active && start;
    assign elem_done = active && (pc.two_step ? sub_q : 1'b1);
    assign last_elem = elem_done && at_end;
    assign run_end   = last_elem && (phase_q == PH_P1_R0);

    assign ctr_load     = start_go || last_elem;
    assign ctr_load_top = start_go ? 1'b0 : nc.descending;
    assign ctr_step     = elem_done && !at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            sub_q   <= 1'b0;
        end else if (start_go) begin
            phase_q <= PH_UP_W0;
            sub_q   <= 1'b0;
        end else if (active) begin
            sub_q <= pc.two_step ? ~sub_q : 1'b0;
            if (last_elem)
                phase_q <= phase_next(phase_q);
        end
    end

    assign phase = phase_q;
    assign sub   = sub_q;

    AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (phase_q <= PH_P1_R0) || (phase_q == PH_IDLE)); // R5

    AST_START_LEAVES_IDLE: assert property (@(posedge clk) disable iff (rst)
        start_go |=> (phase_q == PH_UP_W0)); // R4

    AST_RUN_ENDS_IDLE: assert property (@(posedge clk) disable iff (rst)
        run_end |=> (phase_q == PH_IDLE)); // R4

endmodule

// File: rtl/bist_result.sv
module bist_result #(
    parameter int DATA_W = 72,
    parameter int DEPTH  = 64,
    parameter int PASSES = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_go,
    input  logic              cmp_valid,
    input  logic              down_run,
    input  logic              run_end,
    input  logic              exp_ones,
    input  logic [DATA_W-1:0] rd_data,
    output logic              pass,
    output logic              fail_up,
    output logic              fail_down
);
    localparam int unsigned READS = DEPTH * PASSES;
    localparam int unsigned CNT_W = $clog2(READS + 1);
    localparam logic [CNT_W-1:0] READS_C = CNT_W'(READS);
    localparam logic [CNT_W-1:0] ONE     = {{(CNT_W-1){1'b0}}, 1'b1};

    logic             match;
    logic             good;
    logic [CNT_W-1:0] up_cnt, dn_cnt;
    logic [CNT_W-1:0] up_nxt, dn_nxt;

    assign match  = (rd_data == {DATA_W{exp_ones}});
    assign good   = cmp_valid && match;
    assign up_nxt = up_cnt + ((good && !down_run) ? ONE : '0);
    assign dn_nxt = dn_cnt + ((good &&  down_run) ? ONE : '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            up_cnt    <= '0;
            dn_cnt    <= '0;
            pass      <= 1'b0;
            fail_up   <= 1'b0;
            fail_down <= 1'b0;
        end else if (start_go) begin
            up_cnt    <= '0;
            dn_cnt    <= '0;
            pass      <= 1'b0;
            fail_up   <= 1'b0;
            fail_down <= 1'b0;
        end else begin
            if (cmp_valid) begin
                up_cnt <= up_nxt;
                dn_cnt <= dn_nxt;
            end
            if (run_end) begin
                fail_up   <= (up_nxt != READS_C);
                fail_down <= (dn_nxt != READS_C);
                pass      <= (up_nxt == READS_C) && (dn_nxt == READS_C);
            end
        end
    end

    AST_PASS_FAIL_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(pass && (fail_up || fail_down))); // R7

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!start_go && !run_end) |=> $stable({pass, fail_up, fail_down})); // R10

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        (up_cnt <= READS_C) && (dn_cnt <= READS_C)); // R7

endmodule

// File: rtl/bist_port_mux.sv
module bist_port_mux #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 72,
    parameter int NRD    = 2
) (
    input  logic                       active,
    input  logic [NRD-1:0]             f_rd_en,
    input  logic [NRD-1:0][ADDR_W-1:0] f_rd_addr,
    input  logic [NRD-1:0]             b_rd_en,
    input  logic [NRD-1:0][ADDR_W-1:0] b_rd_addr,
    output logic [NRD-1:0]             o_rd_en,
    output logic [NRD-1:0][ADDR_W-1:0] o_rd_addr,
    input  logic                       f_wr_en,
    input  logic [ADDR_W-1:0]          f_wr_addr,
    input  logic [DATA_W-1:0]          f_wr_data,
    input  logic                       b_wr_en,
    input  logic [ADDR_W-1:0]          b_wr_addr,
    input  logic [DATA_W-1:0]          b_wr_data,
    output logic                       o_wr_en,
    output logic [ADDR_W-1:0]          o_wr_addr,
    output logic [DATA_W-1:0]          o_wr_data
);
    for (genvar i = 0; i < NRD; i++) begin : g_rd
        assign o_rd_en[i]   = active ? b_rd_en[i]   : f_rd_en[i];
        assign o_rd_addr[i] = active ? b_rd_addr[i] : f_rd_addr[i];
    end

    assign o_wr_en   = active ? b_wr_en   : f_wr_en;
    assign o_wr_addr = active ? b_wr_addr : f_wr_addr;
    assign o_wr_data = active ? b_wr_data : f_wr_data;

endmodule

// File: rtl/march_bist_ctrl.sv
module march_bist_ctrl
    import march_bist_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 72,
    parameter int STAT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_start,
    output logic [STAT_W-1:0] status,
    input  logic              fn_rd0_en,
    input  logic [ADDR_W-1:0] fn_rd0_addr,
    input  logic              fn_rd1_en,
    input  logic [ADDR_W-1:0] fn_rd1_addr,
    input  logic              fn_wr_en,
    input  logic [ADDR_W-1:0] fn_wr_addr,
    input  logic [DATA_W-1:0] fn_wr_data,
    output logic              arr_rd0_en,
    output logic [ADDR_W-1:0] arr_rd0_addr,
    input  logic [DATA_W-1:0] arr_rd0_data,
    output logic              arr_rd1_en,
    output logic [ADDR_W-1:0] arr_rd1_addr,
    input  logic [DATA_W-1:0] arr_rd1_data,
    output logic              arr_wr_en,
    output logic [ADDR_W-1:0] arr_wr_addr,
    output logic [DATA_W-1:0] arr_wr_data,
    output logic              test_pass,
    output logic              test_fail,
    output logic              fail_up,
    output logic              fail_down
);
    localparam int DEPTH    = 1 << ADDR_W;
    localparam int NRD      = 2;
    localparam int BIT_PASS = 8;
    localparam int BIT_FUP  = 9;
    localparam int BIT_FDN  = 10;

    phase_e            phase;
    phase_ctl_t        pc;
    logic              sub, active, start_go, run_end;
    logic              ctr_load, ctr_load_top, ctr_step;
    logic [ADDR_W-1:0] addr;
    logic              at_end;
    logic              cmp_valid;
    logic [DATA_W-1:0] cmp_data;
    logic              pass_q, fup_q, fdn_q;

    logic [NRD-1:0]             b_rd_en, f_rd_en, o_rd_en;
    logic [NRD-1:0][ADDR_W-1:0] b_rd_addr, f_rd_addr, o_rd_addr;
    logic                       b_wr_en;
    logic [DATA_W-1:0]          b_wr_data;

    bist_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .start        (run_start),
        .at_end       (at_end),
        .phase        (phase),
        .sub          (sub),
        .active       (active),
        .start_go     (start_go),
        .run_end      (run_end),
        .ctr_load     (ctr_load),
        .ctr_load_top (ctr_load_top),
        .ctr_step     (ctr_step)
    );

    assign pc = phase_decode(phase);

    bist_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .load     (ctr_load),
        .load_top (ctr_load_top),
        .step     (ctr_step),
        .down     (pc.descending),
        .addr     (addr),
        .at_end   (at_end)
    );

    // Read in the first cycle of an element, compare and write in the second
    assign b_rd_en[0]   = active && pc.two_step && !sub && pc.rd0;
    assign b_rd_en[1]   = active && pc.two_step && !sub && pc.rd1;
    assign b_rd_addr[0] = addr;
    assign b_rd_addr[1] = addr;
    assign b_wr_en      = active && pc.wr && (pc.two_step ? sub : 1'b1);
    assign b_wr_data    = {DATA_W{pc.wr_ones}};

    assign f_rd_en[0]   = fn_rd0_en;
    assign f_rd_en[1]   = fn_rd1_en;
    assign f_rd_addr[0] = fn_rd0_addr;
    assign f_rd_addr[1] = fn_rd1_addr;

    bist_port_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NRD(NRD)) u_mux (
        .active    (active),
        .f_rd_en   (f_rd_en),
        .f_rd_addr (f_rd_addr),
        .b_rd_en   (b_rd_en),
        .b_rd_addr (b_rd_addr),
        .o_rd_en   (o_rd_en),
        .o_rd_addr (o_rd_addr),
        .f_wr_en   (fn_wr_en),
        .f_wr_addr (fn_wr_addr),
        .f_wr_data (fn_wr_data),
        .b_wr_en   (b_wr_en),
        .b_wr_addr (addr),
        .b_wr_data (b_wr_data),
        .o_wr_en   (arr_wr_en),
        .o_wr_addr (arr_wr_addr),
        .o_wr_data (arr_wr_data)
    );

    assign arr_rd0_en   = o_rd_en[0];
    assign arr_rd0_addr = o_rd_addr[0];
    assign arr_rd1_en   = o_rd_en[1];
    assign arr_rd1_addr = o_rd_addr[1];

    assign cmp_valid = active && pc.two_step && sub;
    assign cmp_data  = pc.rd1 ? arr_rd1_data : arr_rd0_data;

    bist_result #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PASSES(READ_PASSES)) u_res (
        .clk       (clk),
        .rst       (rst),
        .start_go  (start_go),
        .cmp_valid (cmp_valid),
        .down_run  (pc.down_run),
        .run_end   (run_end),
        .exp_ones  (pc.exp_ones),
        .rd_data   (cmp_data),
        .pass      (pass_q),
        .fail_up   (fup_q),
        .fail_down (fdn_q)
    );

    assign test_pass = pass_q;
    assign test_fail = fup_q || fdn_q;
    assign fail_up   = fup_q;
    assign fail_down = fdn_q;

    always_comb begin
        status                 = '0;
        status[PHASE_W-1:0]    = phase;
        status[BIT_PASS]       = pass_q;
        status[BIT_FUP]        = fup_q;
        status[BIT_FDN]        = fdn_q;
    end

    AST_RD_BEFORE_WR: assert property (@(posedge clk) disable iff (rst)
        (active && pc.two_step && arr_wr_en)
        |-> ($past(arr_rd0_en) && ($past(arr_rd0_addr) == arr_wr_addr))); // R6

endmodule

// File: tb/tb_march_bist_ctrl.sv
module tb_march_bist_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 6;
    localparam int DW = 72;
    localparam int RUN_CYCLES = 896;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic run_start = 1'b0;
    logic [31:0] status;
    logic fn_rd0_en = 0, fn_rd1_en = 0, fn_wr_en = 0;
    logic [AW-1:0] fn_rd0_addr = 0, fn_rd1_addr = 0, fn_wr_addr = 0;
    logic [DW-1:0] fn_wr_data = 0;
    logic arr_rd0_en, arr_rd1_en, arr_wr_en;
    logic [AW-1:0] arr_rd0_addr, arr_rd1_addr, arr_wr_addr;
    logic [DW-1:0] arr_rd0_data, arr_rd1_data, arr_wr_data;
    logic test_pass, test_fail, fail_up, fail_down;

    int n_checks = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    march_bist_ctrl dut (
        .clk(clk), .rst(rst), .run_start(run_start), .status(status),
        .fn_rd0_en(fn_rd0_en), .fn_rd0_addr(fn_rd0_addr),
        .fn_rd1_en(fn_rd1_en), .fn_rd1_addr(fn_rd1_addr),
        .fn_wr_en(fn_wr_en), .fn_wr_addr(fn_wr_addr), .fn_wr_data(fn_wr_data),
        .arr_rd0_en(arr_rd0_en), .arr_rd0_addr(arr_rd0_addr), .arr_rd0_data(arr_rd0_data),
        .arr_rd1_en(arr_rd1_en), .arr_rd1_addr(arr_rd1_addr), .arr_rd1_data(arr_rd1_data),
        .arr_wr_en(arr_wr_en), .arr_wr_addr(arr_wr_addr), .arr_wr_data(arr_wr_data),
        .test_pass(test_pass), .test_fail(test_fail), .fail_up(fail_up), .fail_down(fail_down)
    );

    // Array model: registered reads, optional stuck bit on the read path
    // fault modes: 0 none, 1 always (both ports), 2 while phase<4 (port 0),
    //              3 while phase 4..7 (both ports), 4 port 1 only
    logic [DW-1:0] mem [64];
    logic [2:0]    f_mode = 0;
    logic [AW-1:0] f_addr = 0;
    logic [6:0]    f_bit = 0;
    logic          f_val = 0;
    logic          f_p0, f_p1;

    always_comb begin
        f_p0 = 1'b0;
        f_p1 = 1'b0;
        case (f_mode)
            3'd1: begin f_p0 = 1'b1; f_p1 = 1'b1; end
            3'd2: f_p0 = (status[5:0] < 6'd4);
            3'd3: begin f_p0 = (status[5:0] >= 6'd4); f_p1 = (status[5:0] >= 6'd4); end
            3'd4: f_p1 = 1'b1;
            default: ;
        endcase
    end

    function automatic logic [DW-1:0] apply_fault(input logic [DW-1:0] d, input logic [AW-1:0] a, input logic on);
        logic [DW-1:0] r;
        r = d;
        if (on && a == f_addr) r[f_bit] = f_val;
        return r;
    endfunction

    always @(posedge clk) begin
        if (arr_wr_en) mem[arr_wr_addr] <= arr_wr_data;
        if (arr_rd0_en) arr_rd0_data <= apply_fault(mem[arr_rd0_addr], arr_rd0_addr, f_p0);
        if (arr_rd1_en) arr_rd1_data <= apply_fault(mem[arr_rd1_addr], arr_rd1_addr, f_p1);
    end

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_dwell(input logic [5:0] p);
        return (p == 6'd0 || p == 6'd4) ? 64 : 128;
    endfunction

    // Starts a run and follows it to idle; optional extra start pulse mid-run
    task automatic run_once(input int mid_start_at, input bit do_r3,
                            output int cycles, output int order_bad, output int dwell_bad);
        logic [5:0] prev, cur;
        int dwell;
        @(negedge clk); run_start = 1'b1;
        @(negedge clk); run_start = 1'b0;
        cycles = 0; order_bad = 0; dwell_bad = 0; prev = 6'h3F; dwell = 0;
        while (status[5:0] != 6'h3F && cycles < 2000) begin
            cur = status[5:0];
            if (do_r3 && cycles == 0) begin
                chk("R3", "wr_en first cycle", 64'(arr_wr_en), 64'd1);
                chk("R3", "wr_addr first cycle", 64'(arr_wr_addr), 64'd0);
                chk("R3", "wr_data zero", 64'(arr_wr_data == '0), 64'd1);
                chk("R3", "rd0_en off", 64'(arr_rd0_en), 64'd0);
                chk("R10", "flags cleared at start", 64'({test_pass, fail_up, fail_down}), 64'd0);
            end
            if (cur != prev) begin
                if (prev == 6'h3F) begin
                    if (cur != 6'd0) order_bad++;
                end else begin
                    if (cur != prev + 6'd1) order_bad++;
                    if (dwell != exp_dwell(prev)) dwell_bad++;
                end
                dwell = 0;
                prev = cur;
            end
            dwell++;
            cycles++;
            run_start = (cycles == mid_start_at);
            @(negedge clk);
        end
        run_start = 1'b0;
        if (prev != 6'd7) order_bad++;
        if (dwell != exp_dwell(prev)) dwell_bad++;
    endtask

    typedef struct packed {
        logic [2:0] mode;
        logic [5:0] addr;
        logic [6:0] bitn;
        logic       val;
        logic       e_pass;
        logic       e_up;
        logic       e_dn;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 6'd0,  7'd0,  1'b0, 1'b1, 1'b0, 1'b0},  // clean array
        '{3'd1, 6'd5,  7'd3,  1'b1, 1'b0, 1'b1, 1'b1},  // stuck-1 whole run
        '{3'd1, 6'd0,  7'd70, 1'b0, 1'b0, 1'b1, 1'b1},  // stuck-0 whole run
        '{3'd2, 6'd63, 7'd71, 1'b0, 1'b0, 1'b1, 1'b0},  // ascending only, stuck-0
        '{3'd2, 6'd10, 7'd20, 1'b1, 1'b0, 1'b1, 1'b0},  // ascending only, stuck-1
        '{3'd3, 6'd0,  7'd0,  1'b1, 1'b0, 1'b0, 1'b1},  // descending only
        '{3'd4, 6'd32, 7'd40, 1'b1, 1'b0, 1'b0, 1'b1}   // read port 1 only
    };

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin : main
        int cyc, ob, db;
        for (int i = 0; i < 64; i++) mem[i] = {DW/8{8'hA5}};
        arr_rd0_data = '0;
        arr_rd1_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 / R11 reset state
        chk("R1", "status after reset", 64'(status), 64'h3F);
        chk("R1", "flags after reset", 64'({test_pass, test_fail, fail_up, fail_down}), 64'd0);

        // R2 passthrough while idle
        fn_rd0_en = 1; fn_rd0_addr = 6'd9; fn_rd1_en = 1; fn_rd1_addr = 6'd44;
        fn_wr_en = 0; fn_wr_addr = 6'd17; fn_wr_data = {DW{1'b1}};
        @(negedge clk);
        chk("R2", "rd0 pass", 64'({arr_rd0_en, arr_rd0_addr}), 64'({1'b1, 6'd9}));
        chk("R2", "rd1 pass", 64'({arr_rd1_en, arr_rd1_addr}), 64'({1'b1, 6'd44}));
        chk("R2", "wr pass", 64'({arr_wr_en, arr_wr_addr}), 64'({1'b0, 6'd17}));
        chk("R2", "wr data pass", 64'(arr_wr_data == {DW{1'b1}}), 64'd1);
        fn_rd1_en = 0; fn_wr_en = 1; fn_wr_data = 72'h12_3456_789A_BCDE_F012;
        @(negedge clk);
        chk("R2", "rd1 en follows", 64'(arr_rd1_en), 64'd0);
        chk("R2", "wr en/data follow", 64'({arr_wr_en, arr_wr_data[31:0]}), 64'({1'b1, 32'hBCDE_F012}));
        fn_wr_en = 0; fn_wr_data = {DW{1'b1}};

        // Vector table walk: R4, R5, R7, R8, R9, R11
        for (int v = 0; v < NV; v++) begin
            f_mode = VECS[v].mode; f_addr = VECS[v].addr;
            f_bit = VECS[v].bitn;  f_val = VECS[v].val;
            run_once(-1, (v == 0), cyc, ob, db);
            f_mode = 0;
            chk("R4", "run length", 64'(cyc), 64'(RUN_CYCLES));
            chk("R5", "phase order errors", 64'(ob), 64'd0);
            chk("R5", "phase dwell errors", 64'(db), 64'd0);
            chk(VECS[v].e_pass ? "R7" : (VECS[v].e_up ? "R8" : "R9"), "flags pass/up/dn",
                64'({test_pass, fail_up, fail_down}),
                64'({VECS[v].e_pass, VECS[v].e_up, VECS[v].e_dn}));
            chk("R7", "test_fail", 64'(test_fail), 64'(VECS[v].e_up | VECS[v].e_dn));
            chk("R11", "status word", 64'(status),
                64'({21'd0, VECS[v].e_dn, VECS[v].e_up, VECS[v].e_pass, 2'b00, 6'h3F}));
        end

        // R10 flags held in idle after a fail-up run
        f_mode = 3'd2; f_addr = 6'd3; f_bit = 7'd1; f_val = 1'b1;
        run_once(-1, 1'b0, cyc, ob, db);
        f_mode = 0;
        repeat (25) @(negedge clk);
        chk("R10", "flags held idle", 64'({test_pass, fail_up, fail_down}), 64'b010);
        chk("R11", "status fail_up", 64'(status), 64'h23F);

        // R4 start ignored mid-run, R3 first-cycle ownership, R10 clear on start
        run_once(300, 1'b1, cyc, ob, db);
        chk("R4", "length with mid-run start", 64'(cyc), 64'(RUN_CYCLES));
        chk("R5", "order with mid-run start", 64'(ob + db), 64'd0);
        chk("R7", "clean after restart", 64'({test_pass, fail_up, fail_down}), 64'b100);
        repeat (5) @(negedge clk);
        chk("R10", "pass held idle", 64'(status), 64'h13F);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule